// File: doc/BRIEF.md
# Counted-Loop Memory Summing Engine

This block is the hardware form of a software loop that walks an array in an external synchronous RAM and adds its elements together. A pulse on `start` captures a base address and an element count; the engine then steps an index from zero upward. For each element it issues one read strobe at address base plus index, waits for the RAM's fixed read latency, and adds the returned word into a wide accumulator. When the index reaches the count, the accumulator is copied to the `sum` output and `done` pulses for one cycle.

The loop runs through fixed phases in a set order. An idle/initialise phase clears the index and the accumulator. A test phase compares the index with the count. A request phase drives the address and strobe. An optional wait phase covers the RAM's read latency (`RD_LAT`, 1 to 4 cycles). A take phase accumulates the word and advances the index. A finish phase publishes the result. The engine issues one request at a time, so the RAM needs no queue or arbitration.

Top module: `loop_sum_ctrl`

## Requirements
- R1: After reset, `sum` is 0, `done` is 0 and `mem_rd` is 0.
- R2: `start` is accepted only while the engine is idle; a `start` pulse during a run has no effect on that run's reads, result or timing.
- R3: A run with count N issues exactly N read strobes, at addresses base+0, base+1, ..., base+N-1 in that order, wrapping modulo 2^AW.
- R4: `mem_rd` is high for single cycles only, and `mem_addr` holds the request address during that cycle.
- R5: The word on `mem_rdata` is taken exactly `RD_LAT` rising edges after the edge at which `mem_rd` was high.
- R6: `sum` equals the unsigned sum of the N words read, held in DW+CW bits so that it never overflows, even with N = 2^CW-1 and every word all ones.
- R7: `done` is a one-cycle pulse; `sum` takes its new value on the same edge and does not change at any other time.
- R8: A count of zero makes no read, and the run ends with `sum` = 0 and a `done` pulse.
- R9: `done` rises N*(RD_LAT+2)+2 rising edges after the edge that sampled `start`.
- R10: A new `start` after `done` begins a fresh run with the accumulator cleared, so no earlier total carries over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run; sampled only while idle |
| base_addr | input | AW | Address of the first element |
| elem_count | input | CW | Number of elements to add |
| mem_addr | output | AW | RAM read address |
| mem_rd | output | 1 | RAM read strobe, one cycle per element |
| mem_rdata | input | DW | RAM read data, valid RD_LAT edges after the strobe |
| sum | output | DW+CW | Result of the last completed run |
| done | output | 1 | One-cycle pulse when `sum` is updated |

## Verification
The bench targets these corner cases, each paired with what a faulty design would do:
- A zero count: a design that enters the body before testing the index would read one element and return its value.
- A full-length run of all-ones words with an address that wraps: a narrow accumulator or a bad wrap would give a wrong total, or read outside the window.
- Data taken one cycle early or late against the latency model: the stale or not-yet-valid words would corrupt the total, and the done timing would move off the N*(RD_LAT+2)+2 count.
- A stray `start` in the middle of a run, and runs placed back to back: these expose an engine that restarts, or one that fails to clear its total.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_TEST = 3'd1,
    PH_REQ  = 3'd2,
    PH_WAIT = 3'd3,
    PH_TAKE = 3'd4,
    PH_FIN  = 3'd5
  } phase_t;
endpackage

// File: rtl/lsc_fsm.sv
module lsc_fsm
  import lsc_pkg::*;
#(
  parameter int RD_LAT = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   more,
  output phase_t phase,
  output logic   load_evt,
  output logic   req_evt,
  output logic   take_evt,
  output logic   fin_evt
);
  localparam int WCW = (RD_LAT > 1) ? $clog2(RD_LAT) : 1;

  phase_t phase_q, phase_d;
  logic   wait_last;

  assign phase    = phase_q;
  assign load_evt = (phase_q == PH_IDLE) && start;
  assign req_evt  = (phase_q == PH_REQ);
  assign take_evt = (phase_q == PH_TAKE);
  assign fin_evt  = (phase_q == PH_FIN);

  generate
    if (RD_LAT > 1) begin : g_wait
      logic [WCW-1:0] wcnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          wcnt <= '0;
        else if (req_evt)
          wcnt <= WCW'(RD_LAT - 1);
        else if (phase_q == PH_WAIT)
          wcnt <= wcnt - 1'b1;
      end
      assign wait_last = (wcnt == WCW'(1));
    end else begin : g_nowait
      assign wait_last = 1'b1;
    end
  endgenerate

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE: if (start) phase_d = PH_TEST;
      PH_TEST: phase_d = more ? PH_REQ : PH_FIN;
      PH_REQ:  phase_d = (RD_LAT > 1) ? PH_WAIT : PH_TAKE;
      PH_WAIT: if (wait_last) phase_d = PH_TAKE;
      PH_TAKE: phase_d = PH_TEST;
      PH_FIN:  phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end
endmodule

// File: rtl/lsc_index.sv
module lsc_index #(
  parameter int AW = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_evt,
  input  logic          take_evt,
  input  logic [AW-1:0] base_in,
  input  logic [CW-1:0] count_in,
  output logic [AW-1:0] addr,
  output logic          more,
  output logic [CW-1:0] idx,
  output logic [CW-1:0] limit
);
  logic [AW-1:0] base_q;

  function automatic logic [AW-1:0] elem_addr(input logic [AW-1:0] b,
                                              input logic [CW-1:0] i);
    logic [AW+CW-1:0] wide;
    wide = (AW+CW)'(b) + (AW+CW)'(i);
    return wide[AW-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      limit  <= '0;
      idx    <= '0;
    end else if (load_evt) begin
      base_q <= base_in;
      limit  <= count_in;
      idx    <= '0;
    end else if (take_evt) begin
      idx    <= idx + 1'b1;
    end
  end

  assign addr = elem_addr(base_q, idx);
  assign more = (idx < limit);
endmodule

// File: rtl/lsc_accum.sv
module lsc_accum #(
  parameter int DW = 8,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_evt,
  input  logic          take_evt,
  input  logic          fin_evt,
  input  logic [DW-1:0] word,
  output logic [SW-1:0] result,
  output logic          done
);
  logic [SW-1:0] acc;

  function automatic logic [SW-1:0] add_word(input logic [SW-1:0] a,
                                             input logic [DW-1:0] w);
    return a + SW'(w);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        acc <= '0;
    else if (load_evt) acc <= '0;
    else if (take_evt) acc <= add_word(acc, word);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= fin_evt;
      if (fin_evt) result <= acc;
    end
  end
endmodule

// File: rtl/loop_sum_ctrl.sv
module loop_sum_ctrl
  import lsc_pkg::*;
#(
  parameter int AW     = 8,
  parameter int DW     = 8,
  parameter int CW     = 8,
  parameter int RD_LAT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [AW-1:0]    base_addr,
  input  logic [CW-1:0]    elem_count,
  output logic [AW-1:0]    mem_addr,
  output logic             mem_rd,
  input  logic [DW-1:0]    mem_rdata,
  output logic [DW+CW-1:0] sum,
  output logic             done
);
  localparam int SW = DW + CW;

  phase_t        phase;
  logic          load_evt, req_evt, take_evt, fin_evt, more;
  logic [CW-1:0] idx, limit;

  lsc_fsm #(.RD_LAT(RD_LAT)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .more(more),
    .phase(phase), .load_evt(load_evt), .req_evt(req_evt),
    .take_evt(take_evt), .fin_evt(fin_evt)
  );

  lsc_index #(.AW(AW), .CW(CW)) u_index (
    .clk(clk), .rst_n(rst_n), .load_evt(load_evt), .take_evt(take_evt),
    .base_in(base_addr), .count_in(elem_count), .addr(mem_addr),
    .more(more), .idx(idx), .limit(limit)
  );

  lsc_accum #(.DW(DW), .SW(SW)) u_accum (
    .clk(clk), .rst_n(rst_n), .load_evt(load_evt), .take_evt(take_evt),
    .fin_evt(fin_evt), .word(mem_rdata), .result(sum), .done(done)
  );

  assign mem_rd = req_evt;
endmodule

// File: rtl/lsc_checker.sv
module lsc_checker #(
  parameter int CW     = 8,
  parameter int SW     = 16,
  parameter int RD_LAT = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_rd,
  input logic          take_evt,
  input logic          done,
  input logic [SW-1:0] sum,
  input logic [CW-1:0] idx,
  input logic [CW-1:0] limit
);
  logic [3:0] since_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              since_rd <= '0;
    else if (mem_rd)         since_rd <= 4'd1;
    else if (take_evt)       since_rd <= '0;
    else if (since_rd != 0 && since_rd != 4'hF) since_rd <= since_rd + 1'b1;
  end

  a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);

  a_r5_take_latency: assert property (@(posedge clk) disable iff (!rst_n)
    take_evt |-> (since_rd == 4'(RD_LAT)));

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_sum_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(sum));

  a_r3_index_bound: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= limit);
endmodule

bind loop_sum_ctrl lsc_checker #(.CW(CW), .SW(DW+CW), .RD_LAT(RD_LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .take_evt(take_evt),
  .done(done), .sum(sum), .idx(idx), .limit(limit)
);

// File: tb/loop_sum_ctrl_bench.sv
module loop_sum_ctrl_bench;
  localparam int AW = 8, DW = 8, CW = 8, LAT = 2, SW = DW + CW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic [CW-1:0] elem_count = '0;
  logic [AW-1:0] mem_addr;
  logic          mem_rd;
  logic [DW-1:0] mem_rdata;
  logic [SW-1:0] sum;
  logic          done;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] mem [256];
  logic [DW-1:0] pipe [LAT];

  always #10 clk = ~clk;

  loop_sum_ctrl #(.AW(AW), .DW(DW), .CW(CW), .RD_LAT(LAT)) u_loop_sum_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .elem_count(elem_count), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_rdata(mem_rdata), .sum(sum), .done(done)
  );

  // RAM model: word presented LAT edges after the strobe edge, then held.
  always @(posedge clk) begin
    for (int s = LAT - 1; s > 0; s--) pipe[s] <= pipe[s-1];
    if (mem_rd) pipe[0] <= mem[mem_addr];
  end
  assign mem_rdata = pipe[LAT-1];

  function automatic logic [SW-1:0] ref_sum(input int b, input int n);
    logic [SW-1:0] t = '0;
    for (int i = 0; i < n; i++) t += SW'(mem[(b + i) % 256]);
    return t;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input int b, input int n, input bit stray, input int stray_at);
    int k = 0, reads = 0, bad_addr = 0, got_done = 0;
    logic [SW-1:0] exp;
    exp = ref_sum(b, n);
    @(negedge clk);
    base_addr = AW'(b); elem_count = CW'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    base_addr = ~AW'(b); elem_count = CW'(n + 3);
    while (k < 5000) begin
      @(negedge clk);
      k++;
      if (stray && k == stray_at) start = 1'b1;
      else start = 1'b0;
      if (mem_rd) begin
        if (mem_addr != AW'((b + reads) % 256)) bad_addr++;
        reads++;
      end
      if (done) begin got_done = 1; break; end
    end
    start = 1'b0;
    chk(got_done == 1, "R9 done seen", got_done, 1);
    chk(reads == n, "R3 read count", reads, n);
    chk(bad_addr == 0, "R3 address order", bad_addr, 0);
    chk(sum == exp, "R6 sum value", sum, exp);
    chk(k == n * (LAT + 2) + 2, "R9 done timing", k, n * (LAT + 2) + 2);
    if (stray) chk(k == n * (LAT + 2) + 2 && sum == exp, "R2 stray start ignored", k, n * (LAT + 2) + 2);
    if (n == 0) chk(reads == 0 && sum == 0, "R8 zero count", sum, 0);
    @(negedge clk);
    chk(done == 1'b0, "R7 done one cycle", done, 0);
    chk(sum == exp, "R7 sum holds", sum, exp);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 256; i++) mem[i] = DW'($urandom);
    for (int s = 0; s < LAT; s++) pipe[s] = '0;
    repeat (3) @(negedge clk);
    chk(sum == 0, "R1 reset sum", sum, 0);
    chk(done == 0, "R1 reset done", done, 0);
    chk(mem_rd == 0, "R1 reset strobe", mem_rd, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(mem_rd == 0 && done == 0, "R1 idle after reset", mem_rd, 0);

    run(10, 0, 0, 0);                       // R8
    run(20, 1, 0, 0);
    run(250, 12, 0, 0);                     // R3 wrap
    run(40, 15, 1, 7);                      // R2 stray start
    for (int t = 0; t < 20; t++)            // R10 back-to-back random runs
      run(int'($urandom_range(0, 255)), int'($urandom_range(0, 40)), 0, 0);
    run(7, 3, 0, 0);
    run(7, 0, 0, 0);                        // R10 previous total not carried

    for (int i = 0; i < 256; i++) mem[i] = '1;
    run(128, 255, 0, 0);                    // R6 full-scale, wrap
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 190000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule